// File: doc/BRIEF.md
# Serial Result Reader for a Converter Clocked by the Host

This block sits on the controller side of a three-wire link to a delta-sigma converter that runs with an external serial clock. While the `enable` input is high it holds chip select low, so the converter keeps converting. A single shared line carries both the ready indication and the result bits. While no transfer is running, the reader watches that line. When it sees a high-to-low transition, it knows a fresh 24-bit result is waiting.

The reader then drives the serial clock. The clock rests high. Each pulse goes low and then returns high, and the reader captures one bit on every rising edge, most significant bit first. The 24 pulses come in three bursts of eight, with an extra programmable high gap between bursts, in the way a byte-wide host would fetch the word. The completed word is presented with a one-cycle strobe and held until the next one. A host that does not acknowledge a word before the next ready indication gets an overrun flag.

Top module: `slave_result_reader`

## Requirements
- R1: During reset, chip select (`cs_n`) is high, `sclk` is high, `word_valid` is 0 and `overrun` is 0.
- R2: `cs_n` follows the inverse of `enable` one clock cycle later.
- R3: With chip select low and the data/ready line held high, `sclk` stays high and no transfer starts.
- R4: A transfer produces exactly 24 rising edges of `sclk`, grouped in three bursts of 8.
- R5: Each low phase and each in-burst high phase of `sclk` lasts `div_cfg` cycles, and a value of 0 acts as 1.
- R6: Between bursts (after rising edges 8 and 16), `sclk` stays high for `div_cfg` (0 acting as 1) plus `gap_cfg` cycles.
- R7: The line is sampled as `sclk` rises, and the first bit sampled is bit 23 of `word`, so `word` equals the 24 bits in the order they were sent.
- R8: `word_valid` is a single-cycle pulse, and `word` changes only in the cycle where `word_valid` is high.
- R9: A new transfer starts only after the line has been seen high and then low while no transfer is running. A line that stays low after a read starts nothing.
- R10: When `enable` drops during a transfer, `sclk` returns high, no word is delivered, and the next read after re-enabling delivers a correct word.
- R11: If a transfer starts while a delivered word has not yet been acknowledged with `word_ack`, `overrun` goes to 1. It stays there until `word_ack` clears it in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Select request; high keeps the converter selected |
| div_cfg | input | 8 | Serial clock half-period in system cycles (0 acts as 1) |
| gap_cfg | input | 8 | Extra high cycles inserted between bursts |
| dr_line | input | 1 | Shared data/ready line from the converter |
| word_ack | input | 1 | Host acknowledge of the delivered word |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, resting high |
| word | output | 24 | Last complete result, MSB first |
| word_valid | output | 1 | One-cycle strobe for a new result |
| overrun | output | 1 | Result fetched before the previous one was acknowledged |

## Verification
The hardest case to reach is a deselect that lands partway through the second burst. After it, the reader must drop the partial word, and a clean read must follow once the block is re-enabled. The bench gets there with a behavioural converter model that counts `sclk` rising edges. It pulls `enable` low as soon as ten edges have gone by at a slow clock setting, and afterwards confirms that no strobe appeared and that the next word is exact. The stuck-low line after a read and the unacknowledged second word are set up the same way. The model withholds the line's return to high, or the bench withholds `word_ack`.

// File: rtl/srr_pkg.sv
`timescale 1ns/1ps
package srr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_HIGH,
    PH_GAP
  } phase_e;

  // Effective phase length: a zero setting behaves as one cycle.
  function automatic int unsigned phase_len(input int unsigned cfg);
    return (cfg == 0) ? 1 : cfg;
  endfunction

  // True when a completed-bit count sits on a burst boundary.
  function automatic logic burst_edge(input int unsigned done_bits,
                                      input int unsigned burst);
    return (done_bits % burst) == 0;
  endfunction

endpackage

// File: rtl/srr_ready_watch.sv
`timescale 1ns/1ps
module srr_ready_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic busy,
  input  logic line,
  output logic start
);

  logic line_q;
  logic line_qq;
  logic fall_seen;

  // While deselected the history is forced high, as the line floats up.
  always_ff @(posedge clk) begin
    if (!rst_n || !sel) begin
      line_q  <= 1'b1;
      line_qq <= 1'b1;
    end else begin
      line_q  <= line;
      line_qq <= line_q;
    end
  end

  assign fall_seen = line_qq & ~line_q;
  assign start     = sel & ~busy & fall_seen;

endmodule

// File: rtl/srr_clock_gen.sv
`timescale 1ns/1ps
module srr_clock_gen
  import srr_pkg::*;
#(
  parameter int WORD_BITS  = 24,
  parameter int BURST_BITS = 8,
  parameter int DIV_W      = 8,
  parameter int GAP_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             start,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic [GAP_W-1:0] gap_cfg,
  output logic             sclk,
  output logic             sample_stb,
  output logic             done_stb,
  output logic             busy
);

  localparam int CNT_W = (DIV_W > GAP_W) ? DIV_W : GAP_W;
  localparam int BIT_W = $clog2(WORD_BITS + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_BITS);

  phase_e           state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bits;
  logic             sclk_q;

  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] gap;
  logic             last_tick;
  logic             at_boundary;
  logic             word_full;

  assign half        = CNT_W'(phase_len(32'(div_cfg)));
  assign gap         = CNT_W'(gap_cfg);
  assign last_tick   = (cnt == '0);
  assign word_full   = (bits == LAST_BIT);
  assign at_boundary = burst_edge(32'(bits), BURST_BITS) && (gap != '0);

  assign sample_stb = sel && (state == PH_LOW)  && last_tick;
  assign done_stb   = sel && (state == PH_HIGH) && last_tick && word_full;
  assign busy       = (state != PH_IDLE);
  assign sclk       = sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !sel) begin
      state  <= PH_IDLE;
      sclk_q <= 1'b1;
      cnt    <= '0;
      bits   <= '0;
    end else begin
      unique case (state)
        PH_IDLE: begin
          if (start) begin
            state  <= PH_LOW;
            sclk_q <= 1'b0;
            cnt    <= half - 1'b1;
            bits   <= '0;
          end
        end
        PH_LOW: begin
          if (last_tick) begin
            state  <= PH_HIGH;
            sclk_q <= 1'b1;
            cnt    <= half - 1'b1;
            bits   <= bits + 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HIGH: begin
          if (last_tick) begin
            if (word_full) begin
              state <= PH_IDLE;
            end else if (at_boundary) begin
              state <= PH_GAP;
              cnt   <= gap - 1'b1;
            end else begin
              state  <= PH_LOW;
              sclk_q <= 1'b0;
              cnt    <= half - 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_GAP: begin
          if (last_tick) begin
            state  <= PH_LOW;
            sclk_q <= 1'b0;
            cnt    <= half - 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  // R4
  bits_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bits <= LAST_BIT);

  // R10
  deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (sclk_q && !busy));

  // R5
  low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && $fell(sclk_q) && half > 1) |=> !sclk_q);

  // R3
  rest_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> sclk_q);

endmodule

// File: rtl/srr_word_unit.sv
`timescale 1ns/1ps
module srr_word_unit #(
  parameter int WORD_BITS = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_stb,
  input  logic                 din,
  input  logic                 done_stb,
  input  logic                 start,
  input  logic                 ack,
  output logic [WORD_BITS-1:0] word,
  output logic                 valid,
  output logic                 overrun
);

  logic [WORD_BITS-1:0] shreg;
  logic                 pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
    end else if (sample_stb) begin
      shreg <= {shreg[WORD_BITS-2:0], din};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word    <= '0;
      valid   <= 1'b0;
      pending <= 1'b0;
      overrun <= 1'b0;
    end else begin
      valid <= done_stb;
      if (done_stb) word <= shreg;
      if (done_stb)      pending <= 1'b1;
      else if (ack)      pending <= 1'b0;
      if (ack)                    overrun <= 1'b0;
      else if (start && pending)  overrun <= 1'b1;
    end
  end

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(word));

  // R11
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(pending));

endmodule

// File: rtl/slave_result_reader.sv
`timescale 1ns/1ps
module slave_result_reader #(
  parameter int WORD_BITS  = 24,
  parameter int BURST_BITS = 8,
  parameter int DIV_W      = 8,
  parameter int GAP_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [DIV_W-1:0]     div_cfg,
  input  logic [GAP_W-1:0]     gap_cfg,
  input  logic                 dr_line,
  input  logic                 word_ack,
  output logic                 cs_n,
  output logic                 sclk,
  output logic [WORD_BITS-1:0] word,
  output logic                 word_valid,
  output logic                 overrun
);

  logic cs_n_q;
  logic sel;
  logic start;
  logic busy;
  logic sample_stb;
  logic done_stb;

  always_ff @(posedge clk) begin
    if (!rst_n) cs_n_q <= 1'b1;
    else        cs_n_q <= ~enable;
  end

  assign sel  = ~cs_n_q;
  assign cs_n = cs_n_q;

  srr_ready_watch u_watch (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel),
    .busy  (busy),
    .line  (dr_line),
    .start (start)
  );

  srr_clock_gen #(
    .WORD_BITS  (WORD_BITS),
    .BURST_BITS (BURST_BITS),
    .DIV_W      (DIV_W),
    .GAP_W      (GAP_W)
  ) u_clkgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .start      (start),
    .div_cfg    (div_cfg),
    .gap_cfg    (gap_cfg),
    .sclk       (sclk),
    .sample_stb (sample_stb),
    .done_stb   (done_stb),
    .busy       (busy)
  );

  srr_word_unit #(
    .WORD_BITS (WORD_BITS)
  ) u_word (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .din        (dr_line),
    .done_stb   (done_stb),
    .start      (start),
    .ack        (word_ack),
    .word       (word),
    .valid      (word_valid),
    .overrun    (overrun)
  );

  // R9
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !sclk);

  // R2
  select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> cs_n);

  // R10
  no_word_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !done_stb);

endmodule

// File: tb/slave_result_reader_test.sv
`timescale 1ns/1ps
module slave_result_reader_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [7:0]  div_cfg;
  logic [7:0]  gap_cfg;
  logic        dr;
  logic        word_ack;
  logic        cs_n;
  logic        sclk;
  logic [23:0] word;
  logic        word_valid;
  logic        overrun;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  slave_result_reader uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .div_cfg    (div_cfg),
    .gap_cfg    (gap_cfg),
    .dr_line    (dr),
    .word_ack   (word_ack),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .word       (word),
    .word_valid (word_valid),
    .overrun    (overrun)
  );

  // word, half-period setting, gap setting
  localparam logic [39:0] VEC [6] = '{
    {24'hA5C33C, 8'd1, 8'd0},
    {24'h000001, 8'd2, 8'd3},
    {24'hFFFFFF, 8'd3, 8'd1},
    {24'h800000, 8'd1, 8'd7},
    {24'h5A0F96, 8'd4, 8'd2},
    {24'h123456, 8'd0, 8'd4}
  };

  // Converter model
  logic [23:0] dev_word;
  int  dev_idx   = 0;
  int  dev_rises = 0;
  bit  dev_on    = 0;
  bit  dev_rel   = 1;
  int  falls_total = 0;
  int  valid_cnt   = 0;
  int  lo_len [24];
  int  hi_len [25];
  logic prev_s = 1'b1;
  int  run = 0;

  always @(negedge sclk) begin
    falls_total++;
    if (dev_on && dev_idx < 24) begin
      #1;
      dr = dev_word[23 - dev_idx];
      dev_idx++;
    end
  end

  always @(posedge sclk) begin
    if (dev_on) begin
      dev_rises++;
      if (dev_rises == 24) begin
        dev_on = 0;
        if (dev_rel) begin
          #1;
          dr = 1'b1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (word_valid) valid_cnt++;
    if (sclk === prev_s) run++;
    else begin
      if (prev_s === 1'b0 && dev_rises >= 1 && dev_rises <= 24) lo_len[dev_rises-1] = run;
      if (prev_s === 1'b1 && dev_rises >= 1 && dev_rises <= 23) hi_len[dev_rises] = run;
      run = 1;
    end
    prev_s = sclk;
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int eff_half(input int d);
    if (d < 1) return 1;
    return d;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_read(input logic [23:0] w, input int div, input int gap,
                         input bit rel, input bit ack);
    int t;
    int lo_bad;
    int hi_bad;
    int gap_bad;
    int h;
    @(negedge clk);
    div_cfg = 8'(div);
    gap_cfg = 8'(gap);
    for (int i = 0; i < 24; i++) lo_len[i] = -1;
    for (int i = 0; i < 25; i++) hi_len[i] = -1;
    dev_word = w; dev_idx = 0; dev_rises = 0; dev_rel = rel; dev_on = 1;
    dr = 1'b0;
    t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!word_valid && t < 5000);
    check(word_valid === 1'b1, "R8", "strobe seen", word_valid, 1);
    check(word === w, "R7", "word", word, w);
    check(dev_rises == 24, "R4", "rising edges", dev_rises, 24);
    h = eff_half(div);
    lo_bad = 0; hi_bad = 0; gap_bad = 0;
    for (int i = 0; i < 24; i++) if (lo_len[i] != h) lo_bad++;
    for (int k = 1; k < 24; k++) begin
      if (k == 8 || k == 16) begin
        if (hi_len[k] != h + gap) gap_bad++;
      end else if (hi_len[k] != h) hi_bad++;
    end
    check(lo_bad == 0 && hi_bad == 0, "R5", "phase lengths off", lo_bad + hi_bad, 0);
    check(gap_bad == 0, "R6", "burst gap off", hi_len[8], h + gap);
    @(negedge clk);
    check(word_valid === 1'b0, "R8", "strobe width", word_valid, 0);
    if (ack) begin
      word_ack = 1'b1;
      @(negedge clk);
      word_ack = 1'b0;
    end
    idle(3);
  endtask

  initial begin
    int f0;
    int v0;
    rst_n = 1'b0; enable = 1'b0; dr = 1'b1; word_ack = 1'b0;
    div_cfg = 8'd1; gap_cfg = 8'd0;
    idle(3);
    // R1
    check(cs_n === 1'b1 && sclk === 1'b1, "R1", "cs_n/sclk", {cs_n, sclk}, 2'b11);
    check(word_valid === 1'b0 && overrun === 1'b0, "R1", "valid/overrun",
          {word_valid, overrun}, 0);
    rst_n = 1'b1;
    idle(2);
    check(cs_n === 1'b1, "R2", "deselected", cs_n, 1);
    enable = 1'b1;
    @(negedge clk);
    check(cs_n === 1'b0, "R2", "selected", cs_n, 0);

    // R3: line high, no clock
    f0 = falls_total;
    idle(30);
    check(falls_total == f0 && sclk === 1'b1, "R3", "sclk activity", falls_total - f0, 0);

    // Vector table walk
    for (int i = 0; i < 6; i++) begin
      do_read(VEC[i][39:16], int'(VEC[i][15:8]), int'(VEC[i][7:0]), 1'b1, 1'b1);
    end

    // R8: word held while idle
    idle(20);
    check(word === 24'h123456, "R8", "word held", word, 24'h123456);

    // R9: line left low after read
    do_read(24'h00FF00, 1, 0, 1'b0, 1'b1);
    f0 = falls_total;
    v0 = valid_cnt;
    idle(40);
    check(falls_total == f0 && valid_cnt == v0, "R9", "restart on stuck-low line",
          falls_total - f0, 0);
    dr = 1'b1;
    idle(4);
    do_read(24'h3C3C3C, 2, 1, 1'b1, 1'b1);

    // R11: overrun
    do_read(24'h111111, 1, 0, 1'b1, 1'b0);
    check(overrun === 1'b0, "R11", "no overrun on first", overrun, 0);
    do_read(24'h222222, 1, 0, 1'b1, 1'b0);
    check(overrun === 1'b1, "R11", "overrun set", overrun, 1);
    word_ack = 1'b1;
    @(negedge clk);
    word_ack = 1'b0;
    @(negedge clk);
    check(overrun === 1'b0, "R11", "overrun cleared", overrun, 0);

    // R10: abort in second burst
    @(negedge clk);
    div_cfg = 8'd4; gap_cfg = 8'd2;
    dev_word = 24'hDEAD01; dev_idx = 0; dev_rises = 0; dev_rel = 1; dev_on = 1;
    dr = 1'b0;
    while (dev_rises < 10) @(negedge clk);
    v0 = valid_cnt;
    enable = 1'b0;
    dev_on = 0;
    dr = 1'b1;
    idle(3);
    check(cs_n === 1'b1 && sclk === 1'b1, "R10", "released after abort",
          {cs_n, sclk}, 2'b11);
    idle(60);
    check(valid_cnt == v0, "R10", "no word after abort", valid_cnt - v0, 0);
    enable = 1'b1;
    idle(4);
    do_read(24'hC0FFEE, 3, 2, 1'b1, 1'b1);

    summary();
    $finish;
  end

endmodule